// File: doc/BRIEF.md
# Frame Word Buffer

This block sits behind a serial word receiver and holds the 10-bit words of one received frame until a host drains them. The receiver marks the opening and closing of each frame with single-cycle pulses and delivers each word with a valid pulse and a parity-error flag. The host takes one word per single-cycle read strobe. The oldest unread word is always visible on the data output without waiting for a strobe.

Trouble is reported through an 11-bit data output whose top bit is clear for ordinary words. Three events set a sticky error flag. A word arriving with no free entry sets it. So does a new frame opening while words from an older frame are still unread. A word flagged with bad parity sets it too. While the flag is set, the output shows a reserved code in place of data. Only a synchronous reset clears the error and the stored words.

Top module: `frame_word_buffer`

## Requirements
- R1: After a synchronous reset, empty is 1, full is 0, error is 0 and rd_data is 11'h000.
- R2: After exactly DEPTH words are accepted within one frame, full is 1, empty is 0 and error is 0. full and empty are never 1 together.
- R3: While error is 0 and the buffer is not empty, rd_data equals {1'b0, oldest unread word}. Words leave in the order they arrived.
- R4: Each single-cycle rd_strobe removes one word. After DEPTH strobes on a full buffer, empty is 1 and full is 0.
- R5: An rd_strobe while empty has no effect. A word written afterwards is the next word presented.
- R6: A word accepted while full is dropped. It sets error, full stays 1 and empty stays 0.
- R7: While error is 1, rd_data shows a code with bit 10 set: 11'h401 for overflow and 11'h402 for parity.
- R8: The error flag and its code stay unchanged until reset, whatever reads and writes occur. Reset also empties the buffer.
- R9: A frm_start pulse while the buffer holds unread words sets error with the overflow code, even when the buffer is not full.
- R10: A word with wr_perr set is stored, and it sets error with the parity code.
- R11: When an overflow and a parity error happen in the same cycle, the overflow code is recorded.
- R12: A word is accepted only inside a frame, meaning from the frm_start pulse (the same cycle included) until frm_end. Words outside a frame are ignored. A frm_start on an empty buffer raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_start | input | 1 | Pulse: a frame opens |
| frm_end | input | 1 | Pulse: the current frame closes |
| wr_valid | input | 1 | Pulse: wr_word carries a received word |
| wr_word | input | 10 | Received word |
| wr_perr | input | 1 | Parity error on this word |
| rd_strobe | input | 1 | Host read; removes the oldest word |
| rd_data | output | 11 | Oldest word with bit 10 clear, or an error code |
| full | output | 1 | All DEPTH entries are occupied |
| empty | output | 1 | No unread words |
| error | output | 1 | Sticky error flag |

## Verification
The bench targets three faults that a plain FIFO bench would miss. An off-by-one count would raise full one word late or let a ninth word overwrite the oldest entry, so the scoreboard would see a wrong first word. A restart check that tested only fullness would miss the frame-restart overflow on a half-filled buffer. A strobe on an empty buffer that still moved the read pointer would surface as a wrong word after the next write. The bench also checks error priority and stickiness: a design that let a later parity error replace the overflow code, or let draining clear the flag, would show the wrong code on rd_data.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
    localparam int WORD_W = 10;
    localparam int OUT_W  = WORD_W + 1;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_OVF  = 2'd1,
        ERR_PAR  = 2'd2
    } err_kind_e;

    // Codes live above every legal word because bit WORD_W is set.
    localparam logic [OUT_W-1:0] CODE_OVF = {1'b1, WORD_W'(1)};
    localparam logic [OUT_W-1:0] CODE_PAR = {1'b1, WORD_W'(2)};

    typedef struct packed {
        logic      in_frame;
        err_kind_e err;
    } top_st_t;
endpackage

// File: rtl/fwb_store.sv
module fwb_store
    import fwb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 3
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/fwb_ptrs.sv
module fwb_ptrs #(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr = bump(st_q.wr);
        if (pop)  st_d.rd = bump(st_q.rd);
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wr_ptr = st_q.wr;
    assign rd_ptr = st_q.rd;
    assign full   = (st_q.cnt == CW'(DEPTH));
    assign empty  = (st_q.cnt == '0);
endmodule

// File: rtl/frame_word_buffer.sv
module frame_word_buffer
    import fwb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_start,
    input  logic              frm_end,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              wr_perr,
    input  logic              rd_strobe,
    output logic [OUT_W-1:0]  rd_data,
    output logic              full,
    output logic              empty,
    output logic              error
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    top_st_t st_d, st_q;
    logic    in_frame_q;
    logic    accept, push, pop, ovf_word, ovf_frame;
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [WORD_W-1:0] head_word;

    assign in_frame_q = st_q.in_frame;

    fwb_ptrs #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptrs (
        .clk    (clk),
        .rst    (rst),
        .push   (push),
        .pop    (pop),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .full   (full),
        .empty  (empty)
    );

    fwb_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (push),
        .wr_addr (wr_ptr),
        .wr_data (wr_word),
        .rd_addr (rd_ptr),
        .rd_data (head_word)
    );

    always_comb begin
        accept    = wr_valid && (in_frame_q || frm_start);
        ovf_word  = accept && full;
        ovf_frame = frm_start && !empty;
        push      = accept && !full;
        pop       = rd_strobe && !empty;

        st_d = st_q;
        if (frm_start)    st_d.in_frame = 1'b1;
        else if (frm_end) st_d.in_frame = 1'b0;

        // First error wins and is kept; overflow outranks parity.
        if (st_q.err == ERR_NONE) begin
            if (ovf_word || ovf_frame)  st_d.err = ERR_OVF;
            else if (push && wr_perr)   st_d.err = ERR_PAR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{in_frame: 1'b0, err: ERR_NONE};
        else     st_q <= st_d;
    end

    always_comb begin
        case (st_q.err)
            ERR_OVF: rd_data = CODE_OVF;
            ERR_PAR: rd_data = CODE_PAR;
            default: rd_data = empty ? '0 : {1'b0, head_word};
        endcase
    end

    assign error = (st_q.err != ERR_NONE);
endmodule

// File: rtl/frame_word_buffer_chk.sv
module frame_word_buffer_chk
    import fwb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             frm_start,
    input logic             wr_valid,
    input logic             rd_strobe,
    input logic [OUT_W-1:0] rd_data,
    input logic             full,
    input logic             empty,
    input logic             error,
    input logic             in_frame
);
    assert_full_empty_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    assert_empty_read_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_strobe && !wr_valid) |=> empty);

    assert_overflow_on_full_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && in_frame && full && !error && !rd_strobe)
        |=> (error && full && !empty && rd_data == CODE_OVF));

    assert_code_on_error_R7: assert property (@(posedge clk) disable iff (rst)
        error |-> rd_data[OUT_W-1]);

    assert_error_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        error |=> (error && $stable(rd_data)));

    assert_restart_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (frm_start && !empty && !error) |=> (rd_data == CODE_OVF));
endmodule

bind frame_word_buffer frame_word_buffer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frm_start (frm_start),
    .wr_valid  (wr_valid),
    .rd_strobe (rd_strobe),
    .rd_data   (rd_data),
    .full      (full),
    .empty     (empty),
    .error     (error),
    .in_frame  (in_frame_q)
);

// File: tb/frame_word_buffer_bench.sv
module frame_word_buffer_bench;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        frm_start = 1'b0, frm_end = 1'b0;
    logic        wr_valid = 1'b0, wr_perr = 1'b0, rd_strobe = 1'b0;
    logic [9:0]  wr_word = '0;
    logic [10:0] rd_data;
    logic        full, empty, error;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b1;
    bit done   = 1'b0;
    logic [9:0] exp_q[$];

    frame_word_buffer #(.DEPTH(DEPTH)) u_frame_word_buffer (
        .clk(clk), .rst(rst), .frm_start(frm_start), .frm_end(frm_end),
        .wr_valid(wr_valid), .wr_word(wr_word), .wr_perr(wr_perr),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .full(full),
        .empty(empty), .error(error)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_flags(input string req, input bit f, input bit e, input bit er);
        check(full == f,   {req, " full"},  32'(full),  32'(f));
        check(empty == e,  {req, " empty"}, 32'(empty), 32'(e));
        check(error == er, {req, " error"}, 32'(error), 32'(er));
    endtask

    // Monitor: scoreboard compare of the presented word at each read strobe.
    always @(negedge clk) begin
        #1;
        if (rd_strobe && mon_en && exp_q.size() > 0) begin
            logic [9:0] w;
            w = exp_q.pop_front();
            check(rd_data == {1'b0, w}, "R3 head word", 32'(rd_data), 32'({1'b0, w}));
        end
    end

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        exp_q.delete();
        mon_en = 1'b1;
    endtask

    task automatic pulse_start();
        @(negedge clk); frm_start = 1'b1;
        @(negedge clk); frm_start = 1'b0;
    endtask

    task automatic pulse_end();
        @(negedge clk); frm_end = 1'b1;
        @(negedge clk); frm_end = 1'b0;
    endtask

    task automatic send(input logic [9:0] w, input bit perr, input bit store,
                        input bit with_start);
        @(negedge clk);
        wr_valid = 1'b1; wr_word = w; wr_perr = perr; frm_start = with_start;
        if (store) exp_q.push_back(w);
        @(negedge clk);
        wr_valid = 1'b0; wr_perr = 1'b0; frm_start = 1'b0;
    endtask

    task automatic read_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rd_strobe = 1'b1;
            @(negedge clk); rd_strobe = 1'b0;
        end
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) send(10'((i * 149 + 3) ^ (i == 1 ? 10'h3FF : 10'h0)), 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        // R1 reset state
        do_reset();
        check_flags("R1", 1'b0, 1'b1, 1'b0);
        check(rd_data == 11'h000, "R1 rd_data", 32'(rd_data), 32'h0);

        // R2 fill, R3 order, R4 drain
        pulse_start();
        fill(DEPTH);
        pulse_end();
        check_flags("R2", 1'b1, 1'b0, 1'b0);
        read_n(DEPTH);
        check_flags("R4", 1'b0, 1'b1, 1'b0);
        check(exp_q.size() == 0, "R3 all words seen", 32'(exp_q.size()), 32'h0);

        // R5 read on empty ignored
        read_n(2);
        check(empty == 1'b1, "R5 still empty", 32'(empty), 32'h1);
        pulse_start();
        send(10'h155, 1'b0, 1'b1, 1'b0);
        check(rd_data == 11'h155, "R5 next word after empty reads", 32'(rd_data), 32'h155);
        read_n(1);
        pulse_end();

        // R12 words outside a frame ignored; word with frm_start accepted
        send(10'h2AA, 1'b0, 1'b0, 1'b0);
        check(empty == 1'b1, "R12 outside frame ignored", 32'(empty), 32'h1);
        send(10'h0F0, 1'b0, 1'b1, 1'b1);
        check(rd_data == 11'h0F0, "R12 word with start", 32'(rd_data), 32'h0F0);
        check(error == 1'b0, "R12 start on empty no error", 32'(error), 32'h0);
        read_n(1);
        pulse_end();

        // R6 / R7 overflow by an extra word
        do_reset();
        pulse_start();
        fill(DEPTH);
        send(10'h3C3, 1'b0, 1'b0, 1'b0);
        check_flags("R6", 1'b1, 1'b0, 1'b1);
        check(rd_data == 11'h401, "R7 overflow code", 32'(rd_data), 32'h401);

        // R8 sticky through draining, cleared by reset
        mon_en = 1'b0;
        read_n(DEPTH);
        check(error == 1'b1, "R8 error sticky", 32'(error), 32'h1);
        check(rd_data == 11'h401, "R8 code sticky", 32'(rd_data), 32'h401);
        do_reset();
        check_flags("R8 after reset", 1'b0, 1'b1, 1'b0);

        // R9 frame restart with unread words
        pulse_start();
        fill(3);
        pulse_end();
        check(error == 1'b0, "R9 no error before restart", 32'(error), 32'h0);
        pulse_start();
        check(error == 1'b1, "R9 restart error", 32'(error), 32'h1);
        check(rd_data == 11'h401, "R9 restart code", 32'(rd_data), 32'h401);
        check(full == 1'b0, "R9 not full", 32'(full), 32'h0);

        // R10 parity error, code kept after a later overflow
        do_reset();
        pulse_start();
        send(10'h011, 1'b1, 1'b1, 1'b0);
        check(error == 1'b1, "R10 parity error", 32'(error), 32'h1);
        check(rd_data == 11'h402, "R10 parity code", 32'(rd_data), 32'h402);
        check(empty == 1'b0, "R10 word stored", 32'(empty), 32'h0);
        fill(DEPTH);
        check(rd_data == 11'h402, "R8 first code kept", 32'(rd_data), 32'h402);

        // R11 overflow and parity together
        do_reset();
        pulse_start();
        fill(DEPTH);
        send(10'h077, 1'b1, 1'b0, 1'b0);
        check(rd_data == 11'h401, "R11 overflow wins", 32'(rd_data), 32'h401);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule